// File: doc/BRIEF.md
# Wake Qualification and Attribution Unit

This unit sits between the raw wake inputs of a low-power node and its mode controller. It watches three kinds of wake source: one sampled bus line whose idle (recessive) level is high, a parameterised group of local wake pins that are active high, and a one-cycle timer tick. Each source must pass a qualification stage. The bus line must stay dominant for a programmable number of cycles. A local pin must stay high for a programmable debounce time. The timer tick is taken as it arrives. Every source then passes through its own rate gate. After a programmable number of accepted triggers inside a rate window, the gate shuts that source for a backoff period.

Accepted triggers set bits in a sticky source mask. A priority encoder picks one primary source from that mask, starting at a programmable top-priority index. If the mask goes from empty to non-empty while the node is in a low-power mode, the unit pulses a wake request for one cycle. The host reads the mask, the primary source, the timing setup and a saturating count of rejected triggers through a small register port. It then clears the mask bits it has logged by writing a mask.

Top module: `wake_attrib_unit`

## Requirements
- R1: Source bit positions are as follows. Bit 0 is the bus line. Bit k+1 is local pin k. Bit N_LOCAL+1 is the timer. Every accepted trigger sets its bit in the source mask (`wake_mask`, and bits [7:0] of register 0).
- R2: A bus wake is accepted only when `bus_rx` is low on at least bus-window consecutive clock edges (register 1 bits [15:8], reset value 8). A dominant phase that ends sooner, including a single-cycle one, sets nothing and counts one veto.
- R3: A local pin is accepted only when it is high on at least debounce consecutive clock edges (register 1 bits [7:0], reset value 4). A shorter high phase sets nothing and counts one veto. A pin held high triggers once.
- R4: Each `timer_tick` pulse is a trigger for the timer bit. It is subject only to the rate gate.
- R5: Within a rate window (register 2 bits [7:0], reset 32 cycles), the accepted trigger that brings the count to the limit (register 3 bits [3:0], reset 3; 0 means unlimited) blocks that source for backoff cycles (register 2 bits [15:8], reset 64). Blocked triggers set nothing and each one counts one veto. Other sources are unaffected.
- R6: The primary source (`wake_primary`, register 0 bits [11:8]) is the first set mask bit found by scanning upward from the top-priority index (register 3 bits [4+SRC_W-1:4], reset 0) and wrapping. When the mask is empty it reads 0.
- R7: Register 3 bits [15:8] hold the number of vetoed triggers, saturating at 255. Host writes do not change this count.
- R8: A write to register 0 clears the mask bits that are 1 in the write data. A source accepted in the same cycle as its clear stays set. Writes to other registers leave the mask unchanged.
- R9: `wake_req` is a one-cycle pulse. It is issued only when the mask goes from zero to non-zero while `lp_mode` is high. No pulse is issued when the mask was already non-empty, or when `lp_mode` is low.
- R10: Registers 1 to 3 read back their written configuration fields and come out of reset with the stated defaults.
- R11: After reset the mask is empty, `wake_req` is low and the veto count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rx | input | 1 | Sampled bus line, low = dominant |
| local_pin | input | N_LOCAL | Local wake pins, active high |
| timer_tick | input | 1 | One-cycle timed wake pulse |
| lp_mode | input | 1 | High while the node is in a low-power mode |
| host_addr | input | 2 | Register select |
| host_wr | input | 1 | Register write strobe |
| host_wdata | input | DATA_W | Register write data |
| host_rdata | output | DATA_W | Register read data for `host_addr` |
| wake_req | output | 1 | Wake request pulse to the mode controller |
| wake_mask | output | N_LOCAL+2 | Latched source mask |
| wake_primary | output | SRC_W | Index of the primary source |

## Verification
The bus line is driven with dominant phases one cycle short of the window, exactly at the window, and of a single cycle. These separate acceptance at the threshold from acceptance on a bare edge. Local pins are driven both bouncing and held, and two pins are released together. This shows that the debounce counts correctly, that simultaneous sources all land in the mask, and that the rotating priority picks the right one. Timer bursts at the limit spacing, a bus wake during timer backoff, and a clear written in the very cycle a tick arrives separate per-source blocking from global blocking, and a lost event from a kept one.

// File: rtl/wake_pkg.sv
package wake_pkg;

   parameter int WK_CNT_W = 8;
   parameter int WK_LIM_W = 4;

   typedef enum logic [1:0] {
      REG_STAT = 2'd0,
      REG_QUAL = 2'd1,
      REG_RATE = 2'd2,
      REG_CTRL = 2'd3
   } wake_reg_e;

   typedef struct packed {
      logic [WK_CNT_W-1:0] debounce;
      logic [WK_CNT_W-1:0] bus_win;
      logic [WK_CNT_W-1:0] rate_win;
      logic [WK_CNT_W-1:0] backoff;
      logic [WK_LIM_W-1:0] limit;
   } wake_cfg_t;

   localparam logic [WK_CNT_W-1:0] DEF_DEBOUNCE = 8'd4;
   localparam logic [WK_CNT_W-1:0] DEF_BUS_WIN  = 8'd8;
   localparam logic [WK_CNT_W-1:0] DEF_RATE_WIN = 8'd32;
   localparam logic [WK_CNT_W-1:0] DEF_BACKOFF  = 8'd64;
   localparam logic [WK_LIM_W-1:0] DEF_LIMIT    = 4'd3;

endpackage

// File: rtl/wake_level_qual.sv
module wake_level_qual #(
   parameter bit ACT_HIGH = 1'b1,
   parameter int CNT_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl,
   input  logic [CNT_W-1:0] thr,
   output logic             trig,
   output logic             veto
);

   logic             act;
   logic [CNT_W-1:0] thr_eff;
   logic [CNT_W-1:0] cnt_q;

   if (CNT_W < 2) begin : g_bad_w
      $error("wake_level_qual: CNT_W must be at least 2");
   end

   if (ACT_HIGH) begin : g_pos
      assign act = lvl;
   end else begin : g_neg
      assign act = ~lvl;
   end

   assign thr_eff = (thr == '0) ? CNT_W'(1) : thr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         trig  <= 1'b0;
         veto  <= 1'b0;
      end else begin
         if (act) begin
            if (cnt_q < thr_eff) cnt_q <= cnt_q + 1'b1;
         end else begin
            cnt_q <= '0;
         end
         trig <= act && (cnt_q == thr_eff - 1'b1);
         veto <= !act && (cnt_q != '0) && (cnt_q < thr_eff);
      end
   end

   // R2 / R3: an accepted trigger needs the active level on the edge before it
   assert_qual_hold_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      trig |-> $past(act));

   // R2 / R3: with a threshold of two or more, one edge alone is never enough
   assert_no_single_edge_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (trig && ($past(thr_eff) >= CNT_W'(2))) |-> $past(act, 2));

endmodule

// File: rtl/wake_rate_gate.sv
module wake_rate_gate #(
   parameter int CNT_W = 8,
   parameter int LIM_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig,
   input  logic [CNT_W-1:0] win_len,
   input  logic [CNT_W-1:0] backoff,
   input  logic [LIM_W-1:0] limit,
   output logic             pass,
   output logic             blocked
);

   logic [CNT_W-1:0] win_q;
   logic [CNT_W-1:0] bo_q;
   logic [LIM_W-1:0] hits_q;
   logic [LIM_W-1:0] hits_n;
   logic             at_limit;

   assign pass     = trig && (bo_q == '0);
   assign blocked  = trig && (bo_q != '0);
   assign hits_n   = (win_q != '0) ? hits_q + 1'b1 : LIM_W'(1);
   assign at_limit = (limit != '0) && (hits_n >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q  <= '0;
         bo_q   <= '0;
         hits_q <= '0;
      end else begin
         if (bo_q != '0) bo_q <= bo_q - 1'b1;
         if (pass) begin
            if (at_limit) begin
               bo_q   <= backoff;
               hits_q <= '0;
               win_q  <= '0;
            end else begin
               hits_q <= hits_n;
               win_q  <= (win_q != '0) ? win_q - 1'b1 : win_len;
            end
         end else if (win_q != '0) begin
            win_q <= win_q - 1'b1;
            if (win_q == CNT_W'(1)) hits_q <= '0;
         end
      end
   end

   // R5: the trigger that reaches the limit shuts the source on the next cycle
   assert_backoff_blocks_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (pass && at_limit && (backoff != '0)) |=> !pass);

endmodule

// File: rtl/wake_reason_latch.sv
module wake_reason_latch #(
   parameter int NSRC  = 4,
   parameter int SRC_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  set,
   input  logic             clr_we,
   input  logic [NSRC-1:0]  clr_mask,
   input  logic             lp_mode,
   input  logic [SRC_W-1:0] prio_top,
   output logic [NSRC-1:0]  mask,
   output logic [SRC_W-1:0] primary,
   output logic             wake_req
);

   logic [NSRC-1:0] clr_eff;
   logic            found;

   assign clr_eff = clr_we ? clr_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask     <= '0;
         wake_req <= 1'b0;
      end else begin
         mask     <= (mask & ~clr_eff) | set;
         wake_req <= lp_mode && (mask == '0) && (set != '0);
      end
   end

   always_comb begin
      primary = '0;
      found   = 1'b0;
      for (int i = 0; i < NSRC; i++) begin
         int idx;
         idx = (int'(prio_top) + i) % NSRC;
         if (!found && mask[idx]) begin
            primary = SRC_W'(idx);
            found   = 1'b1;
         end
      end
   end

   // R8: an accepted source is present in the mask on the next cycle, clear or not
   assert_set_survives_clear_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (set != '0) |=> ((mask & $past(set)) == $past(set)));

   // R9: the request marks an empty-to-filled step taken in low-power mode
   assert_req_on_first_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> ((mask != '0) && ($past(mask) == '0) && $past(lp_mode)));

   // R6: the primary source is always one of the latched sources
   assert_primary_in_mask_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (mask != '0) |-> mask[primary]);

endmodule

// File: rtl/wake_host_regs.sv
module wake_host_regs
   import wake_pkg::*;
#(
   parameter int NSRC   = 4,
   parameter int SRC_W  = 2,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        addr,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [NSRC-1:0]   mask,
   input  logic [SRC_W-1:0]  primary,
   input  logic [2*NSRC-1:0] veto_vec,
   output wake_cfg_t         cfg,
   output logic [SRC_W-1:0]  prio_top,
   output logic              clr_we,
   output logic [NSRC-1:0]   clr_mask,
   output logic [DATA_W-1:0] rdata
);

   localparam int VW = $clog2(2 * NSRC + 1);

   logic [7:0]    veto_q;
   logic [VW-1:0] inc;
   logic [8:0]    vsum;

   if (DATA_W < 16) begin : g_bad_dw
      $error("wake_host_regs: DATA_W must be at least 16");
   end
   if (NSRC > 8 || SRC_W > 4) begin : g_bad_src
      $error("wake_host_regs: at most eight sources fit the status layout");
   end

   assign clr_we   = wr && (addr == REG_STAT);
   assign clr_mask = wdata[NSRC-1:0];
   assign inc      = VW'($countones(veto_vec));
   assign vsum     = {1'b0, veto_q} + 9'(inc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg.debounce <= DEF_DEBOUNCE;
         cfg.bus_win  <= DEF_BUS_WIN;
         cfg.rate_win <= DEF_RATE_WIN;
         cfg.backoff  <= DEF_BACKOFF;
         cfg.limit    <= DEF_LIMIT;
         prio_top     <= '0;
         veto_q       <= '0;
      end else begin
         veto_q <= vsum[8] ? 8'hFF : vsum[7:0];
         if (wr) begin
            case (addr)
               REG_QUAL: begin
                  cfg.debounce <= wdata[7:0];
                  cfg.bus_win  <= wdata[15:8];
               end
               REG_RATE: begin
                  cfg.rate_win <= wdata[7:0];
                  cfg.backoff  <= wdata[15:8];
               end
               REG_CTRL: begin
                  cfg.limit <= wdata[3:0];
                  prio_top  <= wdata[4 +: SRC_W];
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         REG_STAT: begin
            rdata[NSRC-1:0]    = mask;
            rdata[8 +: SRC_W]  = primary;
         end
         REG_QUAL: rdata[15:0] = {cfg.bus_win, cfg.debounce};
         REG_RATE: rdata[15:0] = {cfg.backoff, cfg.rate_win};
         default: begin
            rdata[3:0]        = cfg.limit;
            rdata[4 +: SRC_W] = prio_top;
            rdata[15:8]       = veto_q;
         end
      endcase
   end

   // R7: once full, the veto count stays full
   assert_veto_saturates_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (veto_q == 8'hFF) |=> (veto_q == 8'hFF));

endmodule

// File: rtl/wake_attrib_unit.sv
module wake_attrib_unit
   import wake_pkg::*;
#(
   parameter int N_LOCAL = 2,
   parameter int DATA_W  = 16,
   localparam int NSRC   = N_LOCAL + 2,
   localparam int SRC_W  = $clog2(NSRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_rx,
   input  logic [N_LOCAL-1:0] local_pin,
   input  logic               timer_tick,
   input  logic               lp_mode,
   input  logic [1:0]         host_addr,
   input  logic               host_wr,
   input  logic [DATA_W-1:0]  host_wdata,
   output logic [DATA_W-1:0]  host_rdata,
   output logic               wake_req,
   output logic [NSRC-1:0]    wake_mask,
   output logic [SRC_W-1:0]   wake_primary
);

   localparam int TMR_IDX = NSRC - 1;

   wake_cfg_t        cfg;
   logic [SRC_W-1:0] prio_top;
   logic             clr_we;
   logic [NSRC-1:0]  clr_mask;
   logic [NSRC-1:0]  trig;
   logic [NSRC-1:0]  qveto;
   logic [NSRC-1:0]  pass;
   logic [NSRC-1:0]  blocked;

   if (N_LOCAL < 1) begin : g_bad_nl
      $error("wake_attrib_unit: N_LOCAL must be at least 1");
   end

   wake_level_qual #(.ACT_HIGH(1'b0), .CNT_W(WK_CNT_W)) u_bus_qual (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (bus_rx),
      .thr  (cfg.bus_win),
      .trig (trig[0]),
      .veto (qveto[0])
   );

   for (genvar k = 0; k < N_LOCAL; k++) begin : g_pin
      wake_level_qual #(.ACT_HIGH(1'b1), .CNT_W(WK_CNT_W)) u_pin_qual (
         .clk  (clk),
         .rst_n(rst_n),
         .lvl  (local_pin[k]),
         .thr  (cfg.debounce),
         .trig (trig[k+1]),
         .veto (qveto[k+1])
      );
   end

   assign trig[TMR_IDX]  = timer_tick;
   assign qveto[TMR_IDX] = 1'b0;

   for (genvar s = 0; s < NSRC; s++) begin : g_gate
      wake_rate_gate #(.CNT_W(WK_CNT_W), .LIM_W(WK_LIM_W)) u_gate (
         .clk    (clk),
         .rst_n  (rst_n),
         .trig   (trig[s]),
         .win_len(cfg.rate_win),
         .backoff(cfg.backoff),
         .limit  (cfg.limit),
         .pass   (pass[s]),
         .blocked(blocked[s])
      );
   end

   wake_reason_latch #(.NSRC(NSRC), .SRC_W(SRC_W)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .set     (pass),
      .clr_we  (clr_we),
      .clr_mask(clr_mask),
      .lp_mode (lp_mode),
      .prio_top(prio_top),
      .mask    (wake_mask),
      .primary (wake_primary),
      .wake_req(wake_req)
   );

   wake_host_regs #(.NSRC(NSRC), .SRC_W(SRC_W), .DATA_W(DATA_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (host_addr),
      .wr      (host_wr),
      .wdata   (host_wdata),
      .mask    (wake_mask),
      .primary (wake_primary),
      .veto_vec({blocked, qveto}),
      .cfg     (cfg),
      .prio_top(prio_top),
      .clr_we  (clr_we),
      .clr_mask(clr_mask),
      .rdata   (host_rdata)
   );

   // R1: the mask never gains a bit without an accepted trigger for that source
   assert_bits_have_cause_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      ((wake_mask & ~$past(wake_mask)) & ~$past(pass)) == '0);

endmodule

// File: tb/tb_wake_attrib_unit.sv
module tb_wake_attrib_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_rx = 1'b1;
   logic [1:0]  local_pin = 2'b00;
   logic        timer_tick = 1'b0;
   logic        lp_mode = 1'b1;
   logic [1:0]  host_addr = 2'd0;
   logic        host_wr = 1'b0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic        wake_req;
   logic [3:0]  wake_mask;
   logic [1:0]  wake_primary;

   int n_chk = 0;
   int n_fail = 0;
   int reqs = 0;
   bit done = 1'b0;

   wake_attrib_unit dut (
      .clk(clk), .rst_n(rst_n), .bus_rx(bus_rx), .local_pin(local_pin),
      .timer_tick(timer_tick), .lp_mode(lp_mode), .host_addr(host_addr),
      .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .wake_req(wake_req), .wake_mask(wake_mask), .wake_primary(wake_primary)
   );

   always #4 clk = ~clk;

   always @(negedge clk) if (rst_n && wake_req) reqs++;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      @(negedge clk);
      host_addr = a;
      #1;
      v = int'(host_rdata);
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      host_addr  = a;
      host_wdata = d;
      host_wr    = 1'b1;
      @(negedge clk);
      host_wr    = 1'b0;
   endtask

   task automatic bus_low(input int k);
      @(negedge clk);
      bus_rx = 1'b0;
      repeat (k) @(negedge clk);
      bus_rx = 1'b1;
   endtask

   task automatic pins_high(input logic [1:0] p, input int k);
      @(negedge clk);
      local_pin = p;
      repeat (k) @(negedge clk);
      local_pin = 2'b00;
   endtask

   task automatic tick();
      @(negedge clk);
      timer_tick = 1'b1;
      @(negedge clk);
      timer_tick = 1'b0;
   endtask

   function automatic int veto_of(input int r3);
      return (r3 >> 8) & 8'hFF;
   endfunction

   task automatic t_reset();
      int v;
      chk("R11", "mask after reset", int'(wake_mask), 0);
      chk("R11", "wake_req after reset", int'(wake_req), 0);
      rd(2'd0, v); chk("R11", "status after reset", v, 0);
      rd(2'd1, v); chk("R10", "qual defaults", v, 16'h0804);
      rd(2'd2, v); chk("R10", "rate defaults", v, 16'h4020);
      rd(2'd3, v); chk("R10", "ctrl defaults with veto 0 (R11)", v, 16'h0003);
   endtask

   task automatic t_bus();
      int v;
      bus_low(7); cyc(4);
      chk("R2", "mask after 7-cycle dominant", int'(wake_mask), 0);
      rd(2'd3, v); chk("R2", "veto after short dominant", veto_of(v), 1);
      bus_low(1); cyc(4);
      chk("R2", "mask after single-cycle dominant", int'(wake_mask), 0);
      rd(2'd3, v); chk("R2", "veto after single edge", veto_of(v), 2);
      bus_low(8); cyc(4);
      chk("R1", "bus bit 0 set at window", int'(wake_mask), 1);
      chk("R6", "primary is bus", int'(wake_primary), 0);
      chk("R9", "one request from empty mask", reqs, 1);
      wr(2'd0, 16'h000F); cyc(1);
      chk("R8", "mask cleared", int'(wake_mask), 0);
   endtask

   task automatic t_local();
      int v;
      pins_high(2'b01, 3); cyc(4);
      chk("R3", "bounce shorter than debounce ignored", int'(wake_mask), 0);
      rd(2'd3, v); chk("R3", "veto after bounce", veto_of(v), 3);
      pins_high(2'b11, 10); cyc(4);
      chk("R1", "both pins latched at bits 1 and 2", int'(wake_mask), 6);
      chk("R9", "simultaneous sources give one request", reqs, 2);
      chk("R6", "primary from top 0", int'(wake_primary), 1);
      wr(2'd3, 16'h0023); cyc(1);
      chk("R6", "primary from top 2", int'(wake_primary), 2);
      wr(2'd3, 16'h0033); cyc(1);
      chk("R6", "primary from top 3 wraps", int'(wake_primary), 1);
      wr(2'd3, 16'h0003);
      wr(2'd0, 16'h0002); cyc(1);
      chk("R8", "masked clear keeps bit 2", int'(wake_mask), 4);
      rd(2'd0, v); chk("R6", "status shows mask and primary", v, 16'h0204);
   endtask

   task automatic t_req_gating();
      tick(); cyc(3);
      chk("R4", "timer bit 3 latched", int'(wake_mask), 12);
      chk("R9", "no request when mask not empty", reqs, 2);
      wr(2'd0, 16'h000F);
      lp_mode = 1'b0;
      cyc(40);
      tick(); cyc(3);
      chk("R4", "timer latched in normal mode", int'(wake_mask), 8);
      chk("R9", "no request outside low-power mode", reqs, 2);
      wr(2'd0, 16'h000F);
      lp_mode = 1'b1;
   endtask

   task automatic t_rate();
      int v0;
      int v1;
      cyc(40);
      tick(); cyc(1); tick(); cyc(1); tick();
      wr(2'd0, 16'h000F);
      rd(2'd3, v0);
      tick(); cyc(3);
      chk("R5", "tick during backoff sets nothing", int'(wake_mask), 0);
      rd(2'd3, v1);
      chk("R5", "blocked tick counted as veto", veto_of(v1), veto_of(v0) + 1);
      bus_low(8); cyc(4);
      chk("R5", "bus unaffected by timer backoff", int'(wake_mask), 1);
      wr(2'd0, 16'h000F);
      cyc(80);
      tick(); cyc(3);
      chk("R5", "timer accepted after backoff", int'(wake_mask), 8);
   endtask

   task automatic t_race();
      cyc(40);
      @(negedge clk);
      timer_tick = 1'b1;
      host_addr  = 2'd0;
      host_wdata = 16'h0008;
      host_wr    = 1'b1;
      @(negedge clk);
      timer_tick = 1'b0;
      host_wr    = 1'b0;
      cyc(2);
      chk("R8", "set in clear cycle survives", int'(wake_mask), 8);
      wr(2'd1, 16'h0802); cyc(1);
      chk("R8", "other register write keeps mask", int'(wake_mask), 8);
      wr(2'd0, 16'h0008); cyc(1);
      chk("R8", "later clear empties mask", int'(wake_mask), 0);
   endtask

   task automatic t_config();
      int v;
      int v0;
      rd(2'd1, v); chk("R10", "qual readback", v, 16'h0802);
      pins_high(2'b01, 2); cyc(4);
      chk("R10", "new debounce of 2 applied", int'(wake_mask), 2);
      wr(2'd0, 16'h000F);
      wr(2'd2, 16'h2810);
      rd(2'd2, v); chk("R10", "rate readback", v, 16'h2810);
      rd(2'd3, v0);
      wr(2'd3, 16'hFF03);
      rd(2'd3, v);
      chk("R10", "ctrl low byte readback", v & 16'hFF, 16'h03);
      chk("R7", "veto count not writable", veto_of(v), veto_of(v0));
   endtask

   task automatic t_saturate();
      int v;
      for (int i = 0; i < 260; i++) bus_low(1);
      cyc(4);
      rd(2'd3, v);
      chk("R7", "veto count saturates", veto_of(v), 255);
      chk("R2", "single-cycle pulses never wake", int'(wake_mask), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cyc(2);
      t_reset();
      t_bus();
      t_local();
      t_req_gating();
      t_rate();
      t_race();
      t_config();
      t_saturate();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog all requirements actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule